// File: doc/BRIEF.md
# Hypervisor Interrupt Pending and Enable Register Slice

This block holds the machine-level and hypervisor-level interrupt pending and enable state of one hart that implements the hypervisor extension. The same physical bits are reachable through several register addresses: the machine pending view, the machine enable view, the hypervisor pending view, the hypervisor enable view, the virtual-interrupt injection register, and the guest-external enable register. Each address has its own write mask, so a bit can be writable through one address and read-only through another.

A single request port carries an address, an operation (read, write, set bits, clear bits) and write data. A two-state sequencer, `ST_IDLE` and `ST_RESP`, handles each request. In `ST_IDLE` the port is ready, and a valid request is accepted (transition *accept*: `ST_IDLE` to `ST_RESP`). In `ST_RESP` the response is presented for one cycle and the port is not ready. The sequencer then always returns (transition *retire*: `ST_RESP` to `ST_IDLE`). The response carries the value the addressed view held before the access, or an illegal flag. The counter-overflow bit of the injection register is kept apart from the machine counter-overflow pending bit. Hardware lines feed the machine timer, the machine external, the counter-overflow and the guest-external pending state. The combined pending and enable vectors are driven out for the interrupt logic further down the pipeline.

Top module: `hyp_irq_csr`

## Requirements
- R1: After reset every stored pending, enable, injection and guest-enable bit is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. On the next cycle `rsp_valid` is 1, `req_ready` is 0 and `rsp_rdata` holds the view value from before the access. One cycle later `req_ready` is 1 again.
- R3: The operation codes are 0 = read, 1 = write, 2 = set bits, 3 = clear bits. Set and clear are formed against the current view of the addressed register, and the result then passes through that address's write mask. Read leaves state unchanged.
- R4: The injection register (address 0x645) stores bits 2, 6, 10 and 13 only. Every other bit reads 0.
- R5: Writing the injection register never changes bit 13 of the machine pending view (address 0x344, also `irq_pending`).
- R6: Injection bits 2, 6 and 10 read back at the same positions in the machine pending view and in the hypervisor pending view (0x644). The hypervisor pending view shows only bits 2, 6, 10 and 12.
- R7: Bit 2 is one storage bit, writable through the injection register, the hypervisor pending view and the machine pending view. Bits 6 and 10 cannot be changed through 0x644 or 0x344.
- R8: The machine enable register (0x304) stores bits 1, 2, 5, 6, 7, 9, 10, 11, 12 and 13. The hypervisor enable view (0x604) reads and writes bits 2, 6, 10 and 12 of the same storage, and reads 0 elsewhere.
- R9: The guest-enable register (0x607) stores bits 1..GEILEN. Pending bit 12 is the OR over g of `sgei_pend[g-1]` AND guest-enable bit g, and no register write changes it.
- R10: Pending bit 10 equals injection bit 10 OR `sgei_pend[vgein-1]` when `vgein` is in 1..GEILEN. When `vgein` is 0 or above GEILEN, only injection bit 10 counts.
- R11: Pending bit 13 is set by a `lcof_pulse` cycle and written by software through 0x344. When a pulse and a clearing write land on the same edge, the bit ends at 1.
- R12: Pending bits 7 and 11 follow `mtimer_irq` and `mext_irq` directly, and writes do not change them. Machine pending bits 1, 5 and 9 are writable through 0x344.
- R13: An access to any other address responds with `rsp_illegal` = 1 and `rsp_rdata` = 0, and changes no state.
- R14: `irq_pending` always equals the machine pending view and `irq_enable` the machine enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Sequencer idle, request may be accepted |
| req_addr | input | 12 | Register address |
| req_op | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| req_wdata | input | XLEN | Write or mask data |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | XLEN | View value before the access |
| rsp_illegal | output | 1 | Address not implemented |
| mtimer_irq | input | 1 | Machine timer pending line |
| mext_irq | input | 1 | Machine external pending line |
| lcof_pulse | input | 1 | Counter-overflow event |
| sgei_pend | input | GEILEN | Guest-external pending lines |
| vgein | input | VGW | Selected guest-external line, 0 = none |
| irq_pending | output | XLEN | Machine pending view |
| irq_enable | output | XLEN | Machine enable register |

## Verification
The bench builds the block with XLEN = 64 and GEILEN = 4, which makes `vgein` three bits wide. With these values it can sweep every injection pattern and every hypervisor-enable pattern, every guest-pending word against every `vgein` code (including the three codes above GEILEN), and several guest-enable words. It computes each expected view from a small model of the requirements, and it drives the counter-overflow pulse on the same edge as a clearing write.

// File: rtl/hirq_pkg.sv
package hirq_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } csr_op_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MIP,
        SEL_MIE,
        SEL_HIP,
        SEL_HIE,
        SEL_HVIP,
        SEL_HGEIE
    } csr_sel_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } acc_state_e;

    localparam logic [11:0] ADDR_MIE   = 12'h304;
    localparam logic [11:0] ADDR_MIP   = 12'h344;
    localparam logic [11:0] ADDR_HIE   = 12'h604;
    localparam logic [11:0] ADDR_HGEIE = 12'h607;
    localparam logic [11:0] ADDR_HIP   = 12'h644;
    localparam logic [11:0] ADDR_HVIP  = 12'h645;

    localparam int B_SSIP  = 1;
    localparam int B_VSSIP = 2;
    localparam int B_STIP  = 5;
    localparam int B_VSTIP = 6;
    localparam int B_MTIP  = 7;
    localparam int B_SEIP  = 9;
    localparam int B_VSEIP = 10;
    localparam int B_MEIP  = 11;
    localparam int B_SGEIP = 12;
    localparam int B_LCOF  = 13;

    // masks over the low 14 bits, widened in the modules
    localparam logic [13:0] M_MIP_SW  = 14'h2222; // SSIP STIP SEIP LCOF
    localparam logic [13:0] M_MIE     = 14'h3EE6;
    localparam logic [13:0] M_HSHARE  = 14'h1444; // VSSIP VSTIP VSEIP SGEIP
    localparam logic [13:0] M_HVIP    = 14'h2444;
    localparam logic [13:0] M_VSSIP   = 14'h0004;

    function automatic csr_sel_e decode_addr(input logic [11:0] a);
        csr_sel_e s;
        unique case (a)
            ADDR_MIP:   s = SEL_MIP;
            ADDR_MIE:   s = SEL_MIE;
            ADDR_HIP:   s = SEL_HIP;
            ADDR_HIE:   s = SEL_HIE;
            ADDR_HVIP:  s = SEL_HVIP;
            ADDR_HGEIE: s = SEL_HGEIE;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/hirq_access_fsm.sv
module hirq_access_fsm
    import hirq_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  csr_sel_e        sel,
    input  logic [XLEN-1:0] cur_view,
    output logic            req_ready,
    output logic            accept,
    output logic            rsp_valid,
    output logic [XLEN-1:0] rsp_rdata,
    output logic            rsp_illegal
);

    acc_state_e state_q, state_d;
    logic [XLEN-1:0] rdata_q;
    logic            illegal_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        accept    = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                accept    = req_valid;
                if (req_valid) state_d = ST_RESP;   // accept
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                state_d   = ST_IDLE;                // retire
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q   <= '0;
            illegal_q <= 1'b0;
        end else if (accept) begin
            rdata_q   <= (sel == SEL_NONE) ? '0 : cur_view;
            illegal_q <= (sel == SEL_NONE);
        end
    end

    assign rsp_rdata   = rdata_q;
    assign rsp_illegal = illegal_q;

endmodule

// File: rtl/hirq_store.sv
module hirq_store
    import hirq_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int GEILEN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  csr_sel_e        sel,
    input  csr_op_e         op,
    input  logic [XLEN-1:0] wdata,
    input  logic [XLEN-1:0] cur_view,
    input  logic            lcof_pulse,
    output logic [XLEN-1:0] hvip_q,
    output logic [XLEN-1:0] mipsw_q,
    output logic [XLEN-1:0] mie_q,
    output logic [XLEN-1:0] hgeie_q
);

    localparam logic [XLEN-1:0] W_MIP_SW = XLEN'(M_MIP_SW);
    localparam logic [XLEN-1:0] W_MIE    = XLEN'(M_MIE);
    localparam logic [XLEN-1:0] W_HSHARE = XLEN'(M_HSHARE);
    localparam logic [XLEN-1:0] W_HVIP   = XLEN'(M_HVIP);
    localparam logic [XLEN-1:0] W_VSSIP  = XLEN'(M_VSSIP);
    localparam logic [XLEN-1:0] W_HGEIE  = XLEN'(((XLEN+1)'(1) << GEILEN) - 1) << 1;

    logic [XLEN-1:0] newv;
    logic [XLEN-1:0] hvip_d, mipsw_d, mie_d, hgeie_d;

    function automatic logic [XLEN-1:0] merge(input logic [XLEN-1:0] old,
                                              input logic [XLEN-1:0] nv,
                                              input logic [XLEN-1:0] m);
        return (old & ~m) | (nv & m);
    endfunction

    always_comb begin
        unique case (op)
            OP_SET:   newv = cur_view | wdata;
            OP_CLEAR: newv = cur_view & ~wdata;
            default:  newv = wdata;
        endcase
    end

    always_comb begin
        hvip_d  = hvip_q;
        mipsw_d = mipsw_q;
        mie_d   = mie_q;
        hgeie_d = hgeie_q;
        if (wr_en) begin
            unique case (sel)
                SEL_MIP: begin
                    mipsw_d = merge(mipsw_q, newv, W_MIP_SW);
                    hvip_d  = merge(hvip_q, newv, W_VSSIP);
                end
                SEL_HIP:   hvip_d  = merge(hvip_q, newv, W_VSSIP);
                SEL_HVIP:  hvip_d  = merge(hvip_q, newv, W_HVIP);
                SEL_MIE:   mie_d   = merge(mie_q, newv, W_MIE);
                SEL_HIE:   mie_d   = merge(mie_q, newv, W_HSHARE);
                SEL_HGEIE: hgeie_d = merge(hgeie_q, newv, W_HGEIE);
                default: ;
            endcase
        end
        // hardware overflow event wins over a same-cycle write
        if (lcof_pulse) mipsw_d[B_LCOF] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hvip_q  <= '0;
            mipsw_q <= '0;
            mie_q   <= '0;
            hgeie_q <= '0;
        end else begin
            hvip_q  <= hvip_d;
            mipsw_q <= mipsw_d;
            mie_q   <= mie_d;
            hgeie_q <= hgeie_d;
        end
    end

endmodule

// File: rtl/hirq_view.sv
module hirq_view
    import hirq_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int GEILEN = 4,
    parameter int VGW    = 3
) (
    input  csr_sel_e        sel,
    input  logic [XLEN-1:0] hvip_q,
    input  logic [XLEN-1:0] mipsw_q,
    input  logic [XLEN-1:0] mie_q,
    input  logic [XLEN-1:0] hgeie_q,
    input  logic            mtimer_irq,
    input  logic            mext_irq,
    input  logic [GEILEN-1:0] sgei_pend,
    input  logic [VGW-1:0]  vgein,
    output logic [XLEN-1:0] mip_view,
    output logic [XLEN-1:0] cur_view
);

    localparam logic [XLEN-1:0] W_MIP_SW = XLEN'(M_MIP_SW);
    localparam logic [XLEN-1:0] W_HSHARE = XLEN'(M_HSHARE);

    logic [GEILEN-1:0] line_hit;
    logic              sel_line;
    logic              sgeip;

    for (genvar g = 0; g < GEILEN; g++) begin : g_line
        assign line_hit[g] = (vgein == VGW'(g + 1)) && sgei_pend[g];
    end

    assign sel_line = |line_hit;
    assign sgeip    = |(sgei_pend & hgeie_q[GEILEN:1]);

    always_comb begin
        mip_view          = mipsw_q & W_MIP_SW;
        mip_view[B_VSSIP] = hvip_q[B_VSSIP];
        mip_view[B_VSTIP] = hvip_q[B_VSTIP];
        mip_view[B_VSEIP] = hvip_q[B_VSEIP] | sel_line;
        mip_view[B_MTIP]  = mtimer_irq;
        mip_view[B_MEIP]  = mext_irq;
        mip_view[B_SGEIP] = sgeip;
    end

    always_comb begin
        unique case (sel)
            SEL_MIP:   cur_view = mip_view;
            SEL_MIE:   cur_view = mie_q;
            SEL_HIP:   cur_view = mip_view & W_HSHARE;
            SEL_HIE:   cur_view = mie_q & W_HSHARE;
            SEL_HVIP:  cur_view = hvip_q;
            SEL_HGEIE: cur_view = hgeie_q;
            default:   cur_view = '0;
        endcase
    end

endmodule

// File: rtl/hyp_irq_csr.sv
module hyp_irq_csr
    import hirq_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int GEILEN = 4,
    parameter int VGW    = $clog2(GEILEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [11:0]       req_addr,
    input  logic [1:0]        req_op,
    input  logic [XLEN-1:0]   req_wdata,
    output logic              rsp_valid,
    output logic [XLEN-1:0]   rsp_rdata,
    output logic              rsp_illegal,
    input  logic              mtimer_irq,
    input  logic              mext_irq,
    input  logic              lcof_pulse,
    input  logic [GEILEN-1:0] sgei_pend,
    input  logic [VGW-1:0]    vgein,
    output logic [XLEN-1:0]   irq_pending,
    output logic [XLEN-1:0]   irq_enable
);

    csr_sel_e        sel;
    csr_op_e         op;
    logic            accept;
    logic            wr_en;
    logic [XLEN-1:0] cur_view;
    logic [XLEN-1:0] hvip_q, mipsw_q, mie_q, hgeie_q;
    logic [XLEN-1:0] mip_view;

    assign sel   = decode_addr(req_addr);
    assign op    = csr_op_e'(req_op);
    assign wr_en = accept && (op != OP_READ) && (sel != SEL_NONE);

    hirq_access_fsm #(.XLEN(XLEN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .sel        (sel),
        .cur_view   (cur_view),
        .req_ready  (req_ready),
        .accept     (accept),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .rsp_illegal(rsp_illegal)
    );

    hirq_store #(.XLEN(XLEN), .GEILEN(GEILEN)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .sel       (sel),
        .op        (op),
        .wdata     (req_wdata),
        .cur_view  (cur_view),
        .lcof_pulse(lcof_pulse),
        .hvip_q    (hvip_q),
        .mipsw_q   (mipsw_q),
        .mie_q     (mie_q),
        .hgeie_q   (hgeie_q)
    );

    hirq_view #(.XLEN(XLEN), .GEILEN(GEILEN), .VGW(VGW)) u_view (
        .sel       (sel),
        .hvip_q    (hvip_q),
        .mipsw_q   (mipsw_q),
        .mie_q     (mie_q),
        .hgeie_q   (hgeie_q),
        .mtimer_irq(mtimer_irq),
        .mext_irq  (mext_irq),
        .sgei_pend (sgei_pend),
        .vgein     (vgein),
        .mip_view  (mip_view),
        .cur_view  (cur_view)
    );

    assign irq_pending = mip_view;
    assign irq_enable  = mie_q;

endmodule

// File: rtl/hyp_irq_csr_chk.sv
module hyp_irq_csr_chk
    import hirq_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int GEILEN = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [11:0]       req_addr,
    input logic [1:0]        req_op,
    input logic              lcof_pulse,
    input logic [GEILEN-1:0] sgei_pend,
    input logic              rsp_valid,
    input logic [XLEN-1:0]   irq_pending,
    input logic [XLEN-1:0]   irq_enable,
    input logic [XLEN-1:0]   hgeie_q
);

    localparam logic [XLEN-1:0] W_MIE = XLEN'(M_MIE);

    logic acc;
    logic known;
    assign acc   = req_valid && req_ready;
    assign known = (req_addr == ADDR_MIP) || (req_addr == ADDR_MIE) ||
                   (req_addr == ADDR_HIP) || (req_addr == ADDR_HIE) ||
                   (req_addr == ADDR_HVIP) || (req_addr == ADDR_HGEIE);

    p_rsp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (rsp_valid && !req_ready));

    p_hvip_no_leak_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_addr == ADDR_HVIP && req_op != 2'd0 && !lcof_pulse)
        |=> (irq_pending[13] == $past(irq_pending[13])));

    p_sgeip_or_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending[12] == |(sgei_pend & hgeie_q[GEILEN:1]));

    p_illegal_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !known) |=> ($stable(irq_enable) && $stable(hgeie_q)));

    p_mie_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_enable & ~W_MIE) == '0);

endmodule

bind hyp_irq_csr hyp_irq_csr_chk #(.XLEN(XLEN), .GEILEN(GEILEN)) u_chk (.*);

// File: tb/hyp_irq_csr_bench.sv
module hyp_irq_csr_bench;

    localparam int XLEN = 64;
    localparam int GEILEN = 4;
    localparam int VGW = 3;
    localparam logic [11:0] A_MIE = 12'h304, A_MIP = 12'h344, A_HIE = 12'h604,
                            A_HGE = 12'h607, A_HIP = 12'h644, A_HVIP = 12'h645;
    localparam logic [63:0] K_SW = 64'h2222, K_MIE = 64'h3EE6, K_SH = 64'h1444,
                            K_HV = 64'h2444, K_HG = 64'h1E;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_ready;
    logic [11:0] req_addr = '0;
    logic [1:0] req_op = '0;
    logic [63:0] req_wdata = '0;
    logic rsp_valid, rsp_illegal;
    logic [63:0] rsp_rdata, irq_pending, irq_enable;
    logic mtimer_irq = 0, mext_irq = 0, lcof_pulse = 0;
    logic [GEILEN-1:0] sgei_pend = '0;
    logic [VGW-1:0] vgein = '0;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench model of stored state
    logic [63:0] m_hv = 0, m_sw = 0, m_me = 0, m_hg = 0;

    always #2 clk = ~clk;

    hyp_irq_csr #(.XLEN(XLEN), .GEILEN(GEILEN)) u_hyp_irq_csr (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_mip();
        logic [63:0] v;
        logic line;
        line = (vgein >= 1 && vgein <= GEILEN) ? sgei_pend[vgein-1] : 1'b0;
        v = (m_sw & K_SW) | (m_hv & 64'h44);
        v[10] = m_hv[10] | line;
        v[7]  = mtimer_irq;
        v[11] = mext_irq;
        v[12] = |(sgei_pend & m_hg[4:1]);
        return v;
    endfunction

    task automatic csr(input logic [11:0] a, input logic [1:0] op, input logic [63:0] wd,
                       input bit pulse, output logic [63:0] rd, output logic ill);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_op = op; req_wdata = wd; lcof_pulse = pulse;
        @(negedge clk);
        req_valid = 0; lcof_pulse = 0;
        rd = rsp_rdata; ill = rsp_illegal;
        check("R2 rsp_valid/ready", {62'd0, rsp_valid, req_ready}, 64'b10);
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [63:0] exp, input string req);
        logic [63:0] r; logic il;
        csr(a, 2'd0, 64'h0, 0, r, il);
        check(req, r, exp);
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] wd);
        logic [63:0] r; logic il;
        csr(a, 2'd1, wd, 0, r, il);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] r, w;
        logic il;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready/valid", {62'd0, req_ready, rsp_valid}, 64'b10);
        check("R1 pending", irq_pending, 64'h0);
        check("R1 enable", irq_enable, 64'h0);
        rd_chk(A_HVIP, 64'h0, "R1 hvip");
        rd_chk(A_HGE, 64'h0, "R1 guest enable");

        // R4 R5 R6: sweep injection patterns with noise in other bits
        for (int p = 0; p < 16; p++) begin
            w = ~K_HV | (64'(p[0]) << 2) | (64'(p[1]) << 6) | (64'(p[2]) << 10) | (64'(p[3]) << 13);
            csr(A_HVIP, 2'd1, w, 0, r, il);
            check("R2 old value returned", r, m_hv);
            m_hv = w & K_HV;
            rd_chk(A_HVIP, m_hv, "R4 injection readback");
            rd_chk(A_MIP, exp_mip(), "R6 machine pending view");
            check("R5 bit13 isolated", 64'(irq_pending[13]), 64'h0);
            rd_chk(A_HIP, exp_mip() & K_SH, "R6 hypervisor pending view");
        end

        // R7: VSSIP through each address, VSTIP/VSEIP read-only there
        wr(A_HVIP, 64'h0); m_hv = 0;
        wr(A_HIP, '1); m_hv = 64'h4;
        rd_chk(A_HVIP, 64'h4, "R7 hip writes bit2 only");
        csr(A_MIP, 2'd3, 64'h4, 0, r, il); m_hv = 0;
        rd_chk(A_HVIP, 64'h0, "R7 clear bit2 via mip");
        csr(A_MIP, 2'd2, '1, 0, r, il); m_hv = 64'h4; m_sw = K_SW;
        rd_chk(A_HVIP, 64'h4, "R7 set via mip reaches bit2 only");
        rd_chk(A_MIP, exp_mip(), "R12 mip software bits");
        wr(A_HVIP, 64'h444); m_hv = 64'h444;
        wr(A_HIP, 64'h0); m_hv = 64'h440;
        rd_chk(A_HVIP, 64'h440, "R7 hip cannot clear bits 6/10");
        wr(A_MIP, 64'h0); m_hv = 64'h440; m_sw = 0;
        rd_chk(A_MIP, exp_mip(), "R7 mip cannot clear bits 6/10");

        // R3 R8: enable register ops, shared hypervisor view
        csr(A_MIE, 2'd2, '1, 0, r, il); m_me = K_MIE;
        rd_chk(A_MIE, K_MIE, "R3 set then mask");
        csr(A_MIE, 2'd3, 64'h22, 0, r, il); m_me = K_MIE & ~64'h22;
        rd_chk(A_MIE, m_me, "R3 clear bits");
        for (int p = 0; p < 16; p++) begin
            w = ~K_SH | (64'(p[0]) << 2) | (64'(p[1]) << 6) | (64'(p[2]) << 10) | (64'(p[3]) << 12);
            wr(A_HIE, w);
            m_me = (m_me & ~K_SH) | (w & K_SH);
            rd_chk(A_MIE, m_me, "R8 hie write seen in mie");
            rd_chk(A_HIE, m_me & K_SH, "R8 hie view");
            check("R14 irq_enable", irq_enable, m_me);
        end

        // R9 R10: guest enable and selected line sweep
        foreach (K_GE[i]) begin
            wr(A_HGE, '1 & K_GE[i]); m_hg = K_GE[i] & K_HG;
            rd_chk(A_HGE, m_hg, "R9 guest enable readback");
            for (int s = 0; s < 16; s++) begin
                for (int v = 0; v < 8; v++) begin
                    @(negedge clk);
                    sgei_pend = 4'(s); vgein = 3'(v);
                    #1;
                    check("R10 R9 pending vector", irq_pending, exp_mip());
                end
            end
        end
        sgei_pend = 4'hF; vgein = 0;
        wr(A_MIP, 64'h1000); m_sw = 0;
        rd_chk(A_MIP, exp_mip(), "R9 sgeip not writable");
        sgei_pend = 0;

        // R11: counter-overflow pulse
        @(negedge clk); lcof_pulse = 1; @(negedge clk); lcof_pulse = 0; m_sw[13] = 1;
        check("R11 pulse sets bit13", 64'(irq_pending[13]), 64'h1);
        wr(A_MIP, 64'h0); m_sw = 0;
        check("R11 software clear", 64'(irq_pending[13]), 64'h0);
        csr(A_MIP, 2'd3, 64'h2000, 1, r, il); m_sw[13] = 1;
        check("R11 pulse wins over clear", 64'(irq_pending[13]), 64'h1);
        wr(A_HVIP, 64'h0); m_hv = 0;
        check("R5 hvip clear keeps mip bit13", 64'(irq_pending[13]), 64'h1);
        wr(A_MIP, 64'h0); m_sw = 0;
        wr(A_HVIP, 64'h2000); m_hv = 64'h2000;
        check("R5 hvip set leaves mip bit13", 64'(irq_pending[13]), 64'h0);

        // R12: hardware lines
        mtimer_irq = 1; mext_irq = 1; #1;
        check("R12 lines high", irq_pending, exp_mip());
        wr(A_MIP, 64'h0);
        rd_chk(A_MIP, exp_mip(), "R12 lines not writable");
        mtimer_irq = 0; mext_irq = 0; #1;
        check("R12 lines low", irq_pending, exp_mip());

        // R13: unknown address
        w = irq_enable;
        csr(12'h300, 2'd1, '1, 0, r, il);
        check("R13 illegal flag", 64'(il), 64'h1);
        check("R13 rdata zero", r, 64'h0);
        check("R13 enable unchanged", irq_enable, w);
        check("R13 pending unchanged", irq_pending, exp_mip());
        rd_chk(A_HGE, m_hg, "R13 guest enable unchanged");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    localparam logic [63:0] K_GE [3] = '{64'h1E, 64'h0A, 64'hFFFF_FFFF_FFFF_FFFF};

endmodule